// File: doc/BRIEF.md
# Protected Software Event Trigger

This block is a write-only trigger register that lets software raise an event on chosen event lines without any external edge. It sits beside the edge detectors and pending logic of an event controller. A write that sets a bit sends a single-cycle pulse to that line's event input. The bit then clears itself, so nothing stays latched in the register. The pulse enters the event path after the point where rising or falling edges are selected, so it fires whatever edge selection the line has.

Each line carries two protection inputs: one restricts the line to secure bus accesses and the other restricts it to privileged accesses. Every bus write carries matching secure and privileged attributes, and the block checks them line by line. A line whose check fails ignores the write without any error. Other lines in the same write that pass their checks still fire. Reads always return zero. Only a sparse set of lines has a trigger bit, selected by a mask parameter. The line space is wider than the bus and is spread over consecutive bus words.

Top module: `sw_event_trigger`

## Requirements
- R1: After reset, every bit of `trig_pulse` is 0.
- R2: A write (`bus_we`=1) to the word that holds an implemented line, with that line's data bit set to 1 and the access allowed, sets that line's `trig_pulse` bit to 1 in the first cycle after the write edge. Line n sits at bit n mod 32 of the word at `BASE_ADDR` + 4*(n/32); the default mask implements lines 46, 50 and 53.
- R3: Data bits written as 0 produce no pulse on their lines.
- R4: A pulse lasts exactly one cycle. It returns to 0 at the next edge unless a new write fires it again.
- R5: `bus_rdata` is 0 at all times, whatever has been written or configured.
- R6: When `line_sec[n]`=1, a write with `bus_secure`=0 produces no pulse on line n. When `line_sec[n]`=0, both secure and non-secure writes may fire the line.
- R7: When `line_priv[n]`=1, a write with `bus_priv`=0 produces no pulse on line n. When `line_priv[n]`=0, both privileged and unprivileged writes may fire the line.
- R8: The checks in R6 and R7 are applied to each line on its own, so one write can fire some lines while it is dropped for others.
- R9: Lines outside the implemented mask never pulse.
- R10: No pulse appears after a cycle with `bus_we`=0, or after a write to an address that is not a word of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data, one bit per line |
| bus_secure | input | 1 | Access is secure |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | DATA_W | Read data, always zero |
| line_sec | input | NUM_LINES | Per-line secure-only setting |
| line_priv | input | NUM_LINES | Per-line privileged-only setting |
| trig_pulse | output | NUM_LINES | Per-line single-cycle event pulse |

## Verification
The assertions assume that `bus_secure`, `bus_priv`, `line_sec` and `line_priv` are valid in the cycle of the write edge. They compare each pulse with the values those inputs had at the previous edge. They also assume that a write holds `bus_we` high for exactly one cycle. The bench drives every input on the falling edge and keeps the protection settings stable across each write edge. Its random addresses are drawn from the two register words and one unmapped word, so the stimulus stays inside these assumptions while still covering the address-miss case.

// File: rtl/sw_event_trigger.sv
module sw_event_trigger #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 64,
  parameter logic [ADDR_W-1:0]    BASE_ADDR = 12'h0A0,
  parameter logic [NUM_LINES-1:0] IMPL_MASK = 64'h0024_4000_0000_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_secure,
  input  logic                 bus_priv,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] line_sec,
  input  logic [NUM_LINES-1:0] line_priv,
  output logic [NUM_LINES-1:0] trig_pulse
);
  localparam int NUM_WORDS = NUM_LINES / DATA_W;
  localparam int WORD_BYTES = DATA_W / 8;

  logic [NUM_LINES-1:0] spread;
  logic [NUM_LINES-1:0] allowed;
  logic [NUM_LINES-1:0] trig_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(BASE_ADDR + w * WORD_BYTES);
    assign spread[w*DATA_W +: DATA_W] = (bus_addr == WADDR) ? bus_wdata : '0;
  end

  assign allowed = IMPL_MASK
                 & (~line_sec  | {NUM_LINES{bus_secure}})
                 & (~line_priv | {NUM_LINES{bus_priv}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      trig_q <= '0;
    else if (bus_we) trig_q <= spread & allowed;
    else             trig_q <= '0;
  end

  assign trig_pulse = trig_q;
  assign bus_rdata  = '0;
endmodule

module sw_event_trigger_chk #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 64,
  parameter logic [ADDR_W-1:0]    BASE_ADDR = 12'h0A0,
  parameter logic [NUM_LINES-1:0] IMPL_MASK = 64'h0024_4000_0000_0000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic                 bus_secure,
  input logic                 bus_priv,
  input logic [NUM_LINES-1:0] line_sec,
  input logic [NUM_LINES-1:0] line_priv,
  input logic [NUM_LINES-1:0] trig_pulse
);
  localparam int NUM_WORDS = NUM_LINES / DATA_W;
  localparam int WORD_BYTES = DATA_W / 8;

  logic [NUM_LINES-1:0] sec_block, priv_block, data_ones;
  assign sec_block  = bus_secure ? '0 : line_sec;
  assign priv_block = bus_priv   ? '0 : line_priv;

  always_comb begin
    data_ones = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (bus_addr == ADDR_W'(BASE_ADDR + w * WORD_BYTES))
        data_ones[w*DATA_W +: DATA_W] = bus_wdata;
  end

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> trig_pulse == '0);
  a_r3_only_ones: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> (trig_pulse & ~$past(data_ones)) == '0);
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse != '0 && !bus_we) |=> trig_pulse == '0);
  a_r6_secure_gate: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> (trig_pulse & $past(sec_block)) == '0);
  a_r7_priv_gate: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> (trig_pulse & $past(priv_block)) == '0);
  a_r9_unimpl_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse & ~IMPL_MASK) == '0);
  a_r10_no_write_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> trig_pulse == '0);
endmodule

bind sw_event_trigger sw_event_trigger_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES),
  .BASE_ADDR(BASE_ADDR), .IMPL_MASK(IMPL_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_secure(bus_secure), .bus_priv(bus_priv),
  .line_sec(line_sec), .line_priv(line_priv), .trig_pulse(trig_pulse)
);

// File: tb/tb_sw_event_trigger.sv
module tb_sw_event_trigger;
  localparam int AW = 12, DW = 32, NL = 64;
  localparam logic [AW-1:0] BASE = 12'h0A0;
  localparam logic [NL-1:0] IMPL = 64'h0024_4000_0000_0000;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 0, bus_secure = 0, bus_priv = 0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic [NL-1:0] line_sec = '0, line_priv = '0, trig_pulse;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sw_event_trigger dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_secure(bus_secure), .bus_priv(bus_priv),
    .bus_rdata(bus_rdata), .line_sec(line_sec), .line_priv(line_priv),
    .trig_pulse(trig_pulse));

  function automatic logic [NL-1:0] expect_pulse(logic [AW-1:0] a, logic [DW-1:0] d,
      logic s, logic p, logic [NL-1:0] ls, logic [NL-1:0] lp);
    logic [NL-1:0] r = '0;
    if (a == BASE)      r[31:0]  = d;
    if (a == BASE + 4)  r[63:32] = d;
    for (int n = 0; n < NL; n++)
      if (!IMPL[n] || (ls[n] && !s) || (lp[n] && !p)) r[n] = 1'b0;
    return r;
  endfunction

  task automatic check(string req, logic [NL-1:0] act, logic [NL-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(string req, logic [AW-1:0] a, logic [DW-1:0] d, logic s, logic p,
      logic we = 1'b1);
    logic [NL-1:0] e;
    e = we ? expect_pulse(a, d, s, p, line_sec, line_priv) : '0;
    bus_addr = a; bus_wdata = d; bus_secure = s; bus_priv = p; bus_we = we;
    @(negedge clk);
    bus_we = 0;
    check(req, trig_pulse, e);
    check("R5 read zero", {32'h0, bus_rdata}, '0);
    @(negedge clk);
    check("R4 self clear", trig_pulse, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", trig_pulse, '0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", trig_pulse, '0);

    do_write("R2 line 46", BASE + 4, 32'h0000_4000, 0, 0);
    do_write("R2 lines 46 50 53", BASE + 4, 32'h0024_4000, 0, 0);
    do_write("R3 zeros ignored", BASE + 4, 32'h0, 1, 1);
    do_write("R9 unimplemented", BASE, 32'hFFFF_FFFF, 1, 1);
    do_write("R9 upper unimplemented", BASE + 4, 32'hFFDB_BFFF, 1, 1);
    do_write("R10 we low", BASE + 4, 32'hFFFF_FFFF, 1, 1, 1'b0);
    do_write("R10 address miss", BASE + 8, 32'hFFFF_FFFF, 1, 1);

    for (int cfg = 0; cfg < 4; cfg++)
      for (int at = 0; at < 4; at++) begin
        line_sec = '0; line_priv = '0;
        line_sec[46] = cfg[0]; line_priv[46] = cfg[1];
        line_sec[50] = cfg[0]; line_priv[50] = cfg[1];
        @(negedge clk);
        do_write(cfg[0] ? "R6 sec gate" : "R7 priv gate", BASE + 4, 32'h0004_4000, at[0], at[1]);
      end

    line_sec = '0; line_priv = '0;
    line_sec[46] = 1; line_priv[53] = 1;
    @(negedge clk);
    do_write("R8 mixed nonsecure unpriv", BASE + 4, 32'h0024_4000, 0, 0);
    do_write("R8 mixed secure unpriv", BASE + 4, 32'h0024_4000, 1, 0);

    void'($urandom(32'h5A17));
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      int pick;
      line_sec = {$urandom, $urandom}; line_priv = {$urandom, $urandom};
      @(negedge clk);
      pick = int'($urandom % 3);
      a = (pick == 0) ? BASE : (pick == 1) ? BASE + 4 : BASE + 12;
      do_write("R8 random", a, $urandom, $urandom % 2, $urandom % 2, ($urandom % 5) != 0);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule